// File: doc/BRIEF.md
# Event-Mask Interrupt Register Bank

This block is the word-wide control register bank of a network controller. It decodes a 4 KB byte-addressed window into 32-bit word slots, gives each implemented slot its own access behaviour (read-write, write-only, write-one-to-clear or read-only) and returns zero for any slot that is not implemented. Only whole-word accesses exist: the two low address bits are ignored.

Two slots are special. The event slot gathers status bits: internal logic raises them through a per-bit set pulse, and software clears them by writing ones. The mask slot selects which events may interrupt. The masked events are split into three fixed bit groups (transmit, receive, error). Each group drives its own level interrupt output, taken from a register.

Top module: `irq_regbank`

## Requirements
- R1: A slot is chosen by the byte address shifted right by two. Address bits [1:0] have no effect on which slot is read or written.
- R2: After reset these slots hold: event (slot 0) 0, mask (slot 1) 0, slot 2 0x00000055, slots 3-5 zero, slot 8 0x0000FFFF, slot 9 0xF0F0F0F0, slot 10 0x00010203, slot 11 0x80000040. Slots 6-7 read 0.
- R3: Slots 2 to 5 are read-write. A write replaces the value, and a read returns it.
- R4: Slots 6 and 7 are write-only. A write is accepted, but a read always returns zero.
- R5: Slots 8 and 9 are write-one-to-clear. Each bit written as 1 is cleared, and each bit written as 0 keeps its value.
- R6: Writes to the read-only slots 10 and 11 leave them unchanged. Slots 12 to 1023 are unimplemented: they read zero and ignore writes.
- R7: A write to the event slot clears each bit written as 1 and keeps each bit written as 0.
- R8: A write to the mask slot replaces its whole value.
- R9: A bit of the set-pulse input that is high at a clock edge sets the matching event bit. This holds even when a clear of that bit is written at the same edge.
- R10: irq_tx reflects event AND mask over bits [7:0]; irq_rx reflects bits [15:8]; irq_err reflects bits [31:16]. Each output is high when any bit of its group is set.
- R11: The interrupt outputs are low during and after reset. Each output follows the event and mask state one clock after that state changes, which is two edges after the write or set pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe for the addressed slot |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed slot, combinational |
| ev_set | input | 32 | Per-bit event set pulses from internal logic |
| irq_tx | output | 1 | Transmit-group interrupt level |
| irq_rx | output | 1 | Receive-group interrupt level |
| irq_err | output | 1 | Error-group interrupt level |

## Verification
A wrong stored value shows up on rd_data when the slot is next read, on the cycle after the write. A bad event or mask bit shows up one edge later on an interrupt line, if its group has that bit unmasked. The comparison runs against a behavioural model at every clock, so any slip in access behaviour, in group mapping, or in set-versus-clear priority is seen within a cycle or two of the access that exposes it. Writing the low address bits nonzero reveals a decode that uses those bits.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    K_NONE, K_RW, K_WO, K_W1C, K_RO, K_EVT, K_MSK
  } kind_e;

  // Slot map of the bank
  function automatic kind_e kind_of(input int idx);
    if (idx == 0)                  return K_EVT;
    else if (idx == 1)             return K_MSK;
    else if (idx >= 2 && idx <= 5) return K_RW;
    else if (idx == 6 || idx == 7) return K_WO;
    else if (idx == 8 || idx == 9) return K_W1C;
    else if (idx == 10 || idx == 11) return K_RO;
    else                           return K_NONE;
  endfunction

  function automatic logic [WORD_W-1:0] init_of(input int idx);
    case (idx)
      2:  return 32'h0000_0055;
      8:  return 32'h0000_FFFF;
      9:  return 32'hF0F0_F0F0;
      10: return 32'h0001_0203;
      11: return 32'h8000_0040;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] clear_ones(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] wd);
    return cur & ~wd;
  endfunction

  function automatic logic group_hit(input logic [WORD_W-1:0] ev,
                                     input logic [WORD_W-1:0] msk,
                                     input logic [WORD_W-1:0] grp);
    return |(ev & msk & grp);
  endfunction
endpackage

// File: rtl/rb_decode.sv
module rb_decode #(
  parameter int ADDR_W = 12,
  parameter int SLOTS  = 16,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot,
  output logic              hit
);
  logic [ADDR_W-1:0] word_idx;

  always_comb begin
    word_idx = addr >> 2;
    hit      = (word_idx < ADDR_W'(SLOTS));
    slot     = word_idx[SLOT_W-1:0];
  end
endmodule

// File: rtl/rb_event.sv
module rb_event
  import rb_pkg::*;
#(
  parameter logic [WORD_W-1:0] TX_GRP  = 32'h0000_00FF,
  parameter logic [WORD_W-1:0] RX_GRP  = 32'h0000_FF00,
  parameter logic [WORD_W-1:0] ERR_GRP = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] ev_set,
  output logic [WORD_W-1:0] ev_q,
  output logic [WORD_W-1:0] mask_q,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  logic [WORD_W-1:0] ev_cleared;
  logic [WORD_W-1:0] ev_next;

  always_comb begin
    ev_cleared = wr_ev ? clear_ones(ev_q, wr_data) : ev_q;
    ev_next    = ev_cleared | ev_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q    <= init_of(0);
      mask_q  <= init_of(1);
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      ev_q    <= ev_next;
      if (wr_mask) mask_q <= wr_data;
      irq_tx  <= group_hit(ev_q, mask_q, TX_GRP);
      irq_rx  <= group_hit(ev_q, mask_q, RX_GRP);
      irq_err <= group_hit(ev_q, mask_q, ERR_GRP);
    end
  end

  // R9: every pulsed bit is set after the edge
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((ev_q & $past(ev_set)) == $past(ev_set)));

  // R7: write-one-to-clear on the event slot with no set pulse
  p_ev_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && ev_set == '0) |=> (ev_q == ($past(ev_q) & ~$past(wr_data))));

  // R8: mask replaced
  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wr_data)));

  // R10: transmit group follows the previous masked state
  p_tx_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_tx == (|($past(ev_q) & $past(mask_q) & TX_GRP))));

  // R11: nothing masked through means all lines low one clock later
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q & mask_q) == '0) |=> (!irq_tx && !irq_rx && !irq_err));
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import rb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SLOTS  = 16,
  parameter logic [WORD_W-1:0] TX_GRP  = 32'h0000_00FF,
  parameter logic [WORD_W-1:0] RX_GRP  = 32'h0000_FF00,
  parameter logic [WORD_W-1:0] ERR_GRP = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic [WORD_W-1:0] ev_set,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOT_W-1:0] slot;
  logic              hit;
  logic [SLOTS-1:0]  wr_sel;
  logic [WORD_W-1:0] slot_rd [SLOTS];
  logic [WORD_W-1:0] ev_q, mask_q;

  rb_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_dec (
    .addr(acc_addr), .slot(slot), .hit(hit)
  );

  rb_event #(.TX_GRP(TX_GRP), .RX_GRP(RX_GRP), .ERR_GRP(ERR_GRP)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .wr_ev(wr_sel[0]), .wr_mask(wr_sel[1]), .wr_data(wr_data),
    .ev_set(ev_set), .ev_q(ev_q), .mask_q(mask_q),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam kind_e K = kind_of(i);
    localparam logic [WORD_W-1:0] INIT = init_of(i);

    assign wr_sel[i] = wr_en && hit && (slot == SLOT_W'(i));

    if (K == K_EVT) begin : g_evt
      assign slot_rd[i] = ev_q;
    end else if (K == K_MSK) begin : g_msk
      assign slot_rd[i] = mask_q;
    end else if (K == K_RW || K == K_WO || K == K_W1C) begin : g_store
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= INIT;
        else if (wr_sel[i]) q <= (K == K_W1C) ? clear_ones(q, wr_data) : wr_data;
      end
      assign slot_rd[i] = (K == K_WO) ? '0 : q;
      if (K == K_W1C) begin : g_chk
        // R5: written ones cleared, zeros kept
        p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
          wr_sel[i] |=> (q == ($past(q) & ~$past(wr_data))));
      end
    end else if (K == K_RO) begin : g_ro
      assign slot_rd[i] = INIT;
    end else begin : g_none
      assign slot_rd[i] = '0;
    end
  end

  assign rd_data = hit ? slot_rd[slot] : '0;

  // R6: unimplemented addresses read zero
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rd_data == '0));
endmodule

// File: tb/tb_irq_regbank.sv
module tb_irq_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] acc_addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [31:0] ev_set;
  logic        irq_tx, irq_rx, irq_err;

  always #2 clk = ~clk;  // 250 MHz

  irq_regbank dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ev_set(ev_set),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state
  bit [31:0] m_val [16];
  bit        m_itx, m_irx, m_ierr;

  function automatic bit [31:0] m_reset_val(int k);
    bit [31:0] t [16] = '{0, 0, 32'h55, 0, 0, 0, 0, 0,
                          32'h0000FFFF, 32'hF0F0F0F0, 32'h00010203, 32'h80000040,
                          0, 0, 0, 0};
    return t[k];
  endfunction

  function automatic bit [31:0] m_read(bit [11:0] a);
    int k = int'(a) / 4;
    if (k >= 12) return 0;
    if (k == 6 || k == 7) return 0;
    return m_val[k];
  endfunction

  function automatic string tag_for(bit [11:0] a);
    int k = int'(a) / 4;
    if (k == 0) return "R7 R9";
    if (k == 1) return "R8";
    if (k <= 5) return "R3";
    if (k <= 7) return "R4";
    if (k <= 9) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 16; k++) m_val[k] = m_reset_val(k);
    m_itx = 0; m_irx = 0; m_ierr = 0;
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit [11:0] a, bit we, bit [31:0] wd, bit [31:0] st);
    int k;
    acc_addr = a; wr_en = we; wr_data = wd; ev_set = st;
    @(posedge clk);
    m_itx  = |(m_val[0] & m_val[1] & 32'h000000FF);
    m_irx  = |(m_val[0] & m_val[1] & 32'h0000FF00);
    m_ierr = |(m_val[0] & m_val[1] & 32'hFFFF0000);
    k = int'(a) / 4;
    if (we) begin
      if (k == 0) m_val[0] = m_val[0] & ~wd;
      else if (k >= 1 && k <= 7) m_val[k] = wd;
      else if (k == 8 || k == 9) m_val[k] = m_val[k] & ~wd;
    end
    m_val[0] = m_val[0] | st;
    @(negedge clk);
    check({tag_for(a), " R1 read"}, rd_data, m_read(a));
    check("R10 R11 irq_tx", {31'b0, irq_tx}, {31'b0, m_itx});
    check("R10 R11 irq_rx", {31'b0, irq_rx}, {31'b0, m_irx});
    check("R10 R11 irq_err", {31'b0, irq_err}, {31'b0, m_ierr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; acc_addr = 0; wr_en = 0; wr_data = 0; ev_set = 0;
    repeat (3) @(negedge clk);
    check("R11 reset irq", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);
    rst_n = 1;
    model_reset();
    // R2: reset contents of every slot plus one unimplemented address
    for (int k = 0; k < 16; k++) begin
      acc_addr = 12'(k * 4);
      #1;
      check("R2 reset value", rd_data, m_read(12'(k * 4)));
    end
    acc_addr = 12'hFFC; #1;
    check("R6 far slot reads zero", rd_data, 32'h0);
    @(negedge clk);

    // R3 / R1: read-write with nonzero low address bits
    step(12'h00B, 1, 32'hDEAD_BEEF, 0);
    step(12'h008, 0, 0, 0);
    check("R1 low bits ignored", rd_data, 32'hDEAD_BEEF);
    // R4 write-only
    step(12'h018, 1, 32'h1234_5678, 0);
    check("R4 write-only reads zero", rd_data, 32'h0);
    // R5 w1c
    step(12'h020, 1, 32'h0000_0F0F, 0);
    check("R5 w1c partial clear", rd_data, 32'h0000_F0F0);
    // R6 read-only and unimplemented
    step(12'h028, 1, 32'hFFFF_FFFF, 0);
    check("R6 read-only kept", rd_data, 32'h0001_0203);
    step(12'h040, 1, 32'hFFFF_FFFF, 0);
    check("R6 unimplemented zero", rd_data, 32'h0);
    // R8 mask, R9 set, R10 groups, R11 timing
    step(12'h004, 1, 32'h0001_0101, 0);
    step(12'h000, 0, 0, 32'h0000_0001);
    check("R11 irq_tx not yet", {31'b0, irq_tx}, 32'h0);
    step(12'h000, 0, 0, 0);
    check("R10 irq_tx up", {31'b0, irq_tx}, 32'h1);
    // R9: set and clear on same bit in same cycle -> set wins
    step(12'h000, 1, 32'h0000_0001, 32'h0000_0001);
    check("R9 set wins", rd_data & 32'h1, 32'h1);
    step(12'h000, 1, 32'h0000_0001, 0);
    check("R7 event cleared", rd_data, 32'h0);
    step(12'h000, 0, 0, 32'h0001_0100);
    step(12'h000, 0, 0, 0);
    check("R10 rx and err up", {30'b0, irq_rx, irq_err}, 32'h3);
    // R10: event outside mask never interrupts
    step(12'h004, 1, 32'h0, 0);
    step(12'h000, 0, 0, 0);
    check("R10 masked off", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);

    // mixed pattern run against the model
    for (int n = 0; n < 400; n++) begin
      bit [31:0] r = $urandom;
      bit [11:0] a = (r[3:0] == 4'hF) ? 12'(r[31:20]) : {6'b0, r[7:4], r[9:8]};
      bit [31:0] st = r[12] ? (32'h1 << r[17:13]) : 32'h0;
      step(a, r[10], $urandom, st);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule